// File: doc/BRIEF.md
# Nonvolatile SRAM Store Sequencer

This block is a synchronous control model of a battery-free nonvolatile SRAM. It holds a small SRAM register file and a shadow copy that stands in for the nonvolatile cells. It turns the chip-enable, write-enable and store-request pins into one operating mode, and it gates reads and writes of the SRAM. It also runs the hardware store sequence that copies the SRAM into the shadow copy.

A store starts when the active-low store pin has been sampled low for `MIN_PULSE` clocks in a row. The sequencer first lets any SRAM cycle still in progress finish, within a bounded grace window. It then copies the array, but only if a write has been accepted since the last store. It stays inhibited until the pin is released, and then waits out a recovery time before it accepts accesses again. All times are counted in clock cycles set by parameters. The read port drives `rdata_oe` high only while it is driving data; `rdata_oe` low stands for a high-impedance data bus.

States and transitions: IDLE goes to DRAIN once the request is qualified. DRAIN goes to STORE on the first cycle with `ce_n` high, or after `GRACE` cycles. STORE goes to INHIBIT after one cycle if nothing is dirty (skip), and after `STORE_CYC` cycles otherwise (copy). INHIBIT goes to RECOVER when `store_n` is sampled high. RECOVER goes to IDLE after `RECOV` cycles.

Top module: `nvs_store_seq`

## Requirements
- R1: With `ce_n`=1 and `store_n`=1, `rdata_oe` is 0 and no write takes effect, whatever `we_n` is.
- R2: In IDLE with `store_n`=1 and `ce_n`=0, `we_n`=0 writes `wdata` to word `addr` at the clock edge. `we_n`=1 drives the word at `addr` on `rdata` with `rdata_oe`=1 in the same cycle.
- R3: While `store_n`=0, `rdata_oe` is 0 and no write is accepted, except in DRAIN (R10).
- R4: A low on `store_n` that is sampled on fewer than `MIN_PULSE` consecutive rising edges starts no sequence: `busy_n` stays 1 and the shadow copy is unchanged.
- R5: If `store_n` is sampled low on `MIN_PULSE` consecutive edges, `busy_n` goes to 0 after the next edge and stays 0 through DRAIN and STORE. `busy_n` is 1 in every other state.
- R6: If at least one write has been accepted since the last store or skip, STORE lasts `STORE_CYC` cycles and copies every SRAM word into the shadow copy. Shadow word `nv_addr` is visible on `nv_rdata` in the same cycle.
- R7: If no write has been accepted since the last store or skip, STORE lasts one cycle and the shadow copy is left as it is.
- R8: In INHIBIT, `busy_n` is 1, reads and writes are blocked, and the state holds for as long as `store_n` stays 0.
- R9: After `store_n` is sampled high in INHIBIT, accesses stay blocked for `RECOV` cycles. Accesses are then accepted again.
- R10: DRAIN ends at the first edge with `ce_n`=1, or after `GRACE` cycles. A write presented with `ce_n`=0 and `we_n`=0 during DRAIN is accepted and is included in the copy that follows.
- R11: After reset the state is IDLE, `busy_n`=1, `rdata_oe`=0, and the SRAM, the shadow copy and the dirty flag are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| store_n | input | 1 | Hardware store request, active low |
| addr | input | AW | SRAM word address |
| wdata | input | DW | SRAM write data |
| rdata | output | DW | SRAM read data, zero when not driven |
| rdata_oe | output | 1 | High while `rdata` is driven; low stands for high impedance |
| busy_n | output | 1 | Store busy, active low |
| nv_addr | input | AW | Shadow copy word select |
| nv_rdata | output | DW | Shadow copy word contents |

## Verification
The bench builds the block with `AW`=3, `MIN_PULSE`=3, `GRACE`=4, `STORE_CYC`=12 and `RECOV`=4. With these values every phase lasts only a few cycles, so the bench can count the exact number of cycles `busy_n` is low for each case. These counts are 13 for a dirty store with the bus idle, 2 for a skipped store, and 16 for a store that waits out the full grace window. The bench also checks the shadow contents word by word. The short pulse, the blocked writes during inhibit and recovery, and the write that lands during the grace window all fall within a few dozen cycles.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [1:0] {
        MODE_DESEL,
        MODE_READ,
        MODE_WRITE,
        MODE_STORE
    } nvs_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_STORE,
        ST_INHIBIT,
        ST_RECOVER
    } nvs_state_e;

endpackage

// File: rtl/nvs_pulse_filter.sv
// Qualifies the store request: it must be sampled low on MIN_PULSE
// consecutive edges before the sequencer sees it.
module nvs_pulse_filter #(
    parameter int MIN_PULSE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic store_n,
    output logic req
);
    localparam int PW = (MIN_PULSE < 1) ? 1 : $clog2(MIN_PULSE + 1);
    localparam logic [PW-1:0] FULL = PW'(MIN_PULSE);

    logic [PW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (store_n) begin
            low_cnt <= '0;
        end else if (low_cnt != FULL) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign req = (low_cnt == FULL) && !store_n;

endmodule

// File: rtl/nvs_mode_dec.sv
// Decodes the pins into an operating mode and gates array access by sequencer state.
module nvs_mode_dec
    import nvs_pkg::*;
(
    input  logic       ce_n,
    input  logic       we_n,
    input  logic       store_n,
    input  nvs_state_e state,
    output logic       wr_en,
    output logic       rd_oe
);
    nvs_mode_e mode;

    always_comb begin
        if (!store_n)   mode = MODE_STORE;
        else if (ce_n)  mode = MODE_DESEL;
        else if (we_n)  mode = MODE_READ;
        else            mode = MODE_WRITE;
    end

    always_comb begin
        wr_en = 1'b0;
        rd_oe = 1'b0;
        unique case (state)
            ST_IDLE: begin
                wr_en = (mode == MODE_WRITE);
                rd_oe = (mode == MODE_READ);
            end
            // an SRAM cycle still in flight may finish during the grace window
            ST_DRAIN: wr_en = !ce_n && !we_n;
            default: begin
                wr_en = 1'b0;
                rd_oe = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/nvs_store_fsm.sv
// Store sequencer: IDLE -> DRAIN -> STORE -> INHIBIT -> RECOVER -> IDLE.
module nvs_store_fsm
    import nvs_pkg::*;
#(
    parameter int GRACE     = 100,
    parameter int STORE_CYC = 1000000,
    parameter int RECOV     = 70
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       store_n,
    input  logic       ce_n,
    input  logic       wr_en,
    output nvs_state_e state,
    output logic       busy_n,
    output logic       copy_en,
    output logic       dirty
);
    localparam int MAX_AB = (GRACE > STORE_CYC) ? GRACE : STORE_CYC;
    localparam int MAXC   = (MAX_AB > RECOV) ? MAX_AB : RECOV;
    localparam int CW     = (MAXC < 2) ? 1 : $clog2(MAXC);
    localparam logic [CW-1:0] GRACE_LAST = CW'(GRACE - 1);
    localparam logic [CW-1:0] STORE_LAST = CW'(STORE_CYC - 1);
    localparam logic [CW-1:0] RECOV_LAST = CW'(RECOV - 1);

    nvs_state_e st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic          dirty_q;
    logic          store_first;

    assign store_first = (st_q == ST_STORE) && (cnt_q == '0);

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (req) st_d = ST_DRAIN;
            ST_DRAIN:   if (ce_n || cnt_q == GRACE_LAST) st_d = ST_STORE;
            ST_STORE: begin
                if (store_first && !dirty_q)  st_d = ST_INHIBIT;
                else if (cnt_q == STORE_LAST) st_d = ST_INHIBIT;
            end
            ST_INHIBIT: if (store_n) st_d = ST_RECOVER;
            ST_RECOVER: if (cnt_q == RECOV_LAST) st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    // state register with phase counter and dirty flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            cnt_q   <= '0;
            dirty_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_d != st_q)
                cnt_q <= '0;
            else if (st_q == ST_DRAIN || st_q == ST_STORE || st_q == ST_RECOVER)
                cnt_q <= cnt_q + 1'b1;
            if (store_first)
                dirty_q <= 1'b0;
            else if (wr_en)
                dirty_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy_n  = 1'b1;
        copy_en = 1'b0;
        unique case (st_q)
            ST_DRAIN: busy_n = 1'b0;
            ST_STORE: begin
                busy_n  = 1'b0;
                copy_en = store_first && dirty_q;
            end
            default: begin
                busy_n  = 1'b1;
                copy_en = 1'b0;
            end
        endcase
    end

    assign state = st_q;
    assign dirty = dirty_q;

endmodule

// File: rtl/nvs_cell_array.sv
// SRAM register file with a shadow copy standing in for the nonvolatile cells.
module nvs_cell_array #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          copy_en,
    input  logic [AW-1:0] nv_addr,
    output logic [DW-1:0] sram_word,
    output logic [DW-1:0] nv_word
);
    localparam int DEPTH = 1 << AW;

    logic [DEPTH*DW-1:0] sram_flat;
    logic [DEPTH*DW-1:0] nv_flat;

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        logic [DW-1:0] sram_q;
        logic [DW-1:0] nv_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sram_q <= '0;
                nv_q   <= '0;
            end else begin
                if (wr_en && addr == AW'(g))
                    sram_q <= wdata;
                if (copy_en)
                    nv_q <= sram_q;
            end
        end

        assign sram_flat[g*DW +: DW] = sram_q;
        assign nv_flat[g*DW +: DW]   = nv_q;
    end

    assign sram_word = sram_flat[int'(addr)*DW +: DW];
    assign nv_word   = nv_flat[int'(nv_addr)*DW +: DW];

endmodule

// File: rtl/nvs_store_seq.sv
module nvs_store_seq
    import nvs_pkg::*;
#(
    parameter int AW        = 4,
    parameter int DW        = 8,
    parameter int MIN_PULSE = 2,
    parameter int GRACE     = 100,
    parameter int STORE_CYC = 1000000,
    parameter int RECOV     = 70
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          store_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rdata_oe,
    input  logic [AW-1:0] nv_addr,
    output logic [DW-1:0] nv_rdata,
    output logic          busy_n
);
    nvs_state_e    st;
    logic          req;
    logic          wr_en;
    logic          rd_oe;
    logic          copy_en;
    logic          dirty;
    logic [DW-1:0] sram_word;

    nvs_pulse_filter #(.MIN_PULSE(MIN_PULSE)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .store_n (store_n),
        .req     (req)
    );

    nvs_mode_dec u_dec (
        .ce_n    (ce_n),
        .we_n    (we_n),
        .store_n (store_n),
        .state   (st),
        .wr_en   (wr_en),
        .rd_oe   (rd_oe)
    );

    nvs_store_fsm #(
        .GRACE     (GRACE),
        .STORE_CYC (STORE_CYC),
        .RECOV     (RECOV)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .store_n (store_n),
        .ce_n    (ce_n),
        .wr_en   (wr_en),
        .state   (st),
        .busy_n  (busy_n),
        .copy_en (copy_en),
        .dirty   (dirty)
    );

    nvs_cell_array #(.AW(AW), .DW(DW)) u_cells (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .copy_en   (copy_en),
        .nv_addr   (nv_addr),
        .sram_word (sram_word),
        .nv_word   (nv_rdata)
    );

    assign rdata_oe = rd_oe;
    assign rdata    = rd_oe ? sram_word : '0;

endmodule

// File: rtl/nvs_store_seq_chk.sv
module nvs_store_seq_chk
    import nvs_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       ce_n,
    input logic       we_n,
    input logic       store_n,
    input logic       rdata_oe,
    input logic       busy_n,
    input nvs_state_e state,
    input logic       dirty
);

    p_desel_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> !rdata_oe);

    p_store_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !store_n |-> !rdata_oe);

    p_busy_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_n) |-> !$past(store_n));

    p_dirty_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && store_n && !ce_n && !we_n) |=> dirty);

    p_inhibit_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INHIBIT && !store_n) |=> (state == ST_INHIBIT));

    p_inhibit_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INHIBIT) |-> (busy_n && !rdata_oe));

    p_recover_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECOVER) |-> (busy_n && !rdata_oe));

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_n) |-> (state == ST_INHIBIT));

endmodule

bind nvs_store_seq nvs_store_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .we_n     (we_n),
    .store_n  (store_n),
    .rdata_oe (rdata_oe),
    .busy_n   (busy_n),
    .state    (st),
    .dirty    (dirty)
);

// File: tb/sim_nvs_store_seq.sv
`timescale 1ns/1ps
module sim_nvs_store_seq;
    localparam int AW        = 3;
    localparam int DW        = 8;
    localparam int MIN_PULSE = 3;
    localparam int GRACE     = 4;
    localparam int STORE_CYC = 12;
    localparam int RECOV     = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1;
    logic          we_n = 1'b1;
    logic          store_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_oe;
    logic [AW-1:0] nv_addr = '0;
    logic [DW-1:0] nv_rdata;
    logic          busy_n;

    int checks = 0;
    int fails  = 0;
    logic          expect_rd = 1'b0;
    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    always #2 clk = ~clk;

    nvs_store_seq #(
        .AW(AW), .DW(DW), .MIN_PULSE(MIN_PULSE),
        .GRACE(GRACE), .STORE_CYC(STORE_CYC), .RECOV(RECOV)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .store_n(store_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
        .nv_addr(nv_addr), .nv_rdata(nv_rdata), .busy_n(busy_n)
    );

    function automatic logic [DW-1:0] pat(input int i);
        return DW'(8'h3C ^ (i * 8'h11));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected read data for every read the driver issued
    always @(negedge clk) begin
        #1;
        if (expect_rd && exp_q.size() > 0) begin
            logic [DW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (!rdata_oe || rdata !== e) begin
                fails++;
                $display("FAIL %s read oe=%0b actual=%0h expected=%0h", t, rdata_oe, rdata, e);
            end
        end
    end

    task automatic wr(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; addr = AW'(a); wdata = d;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic rd(input int a, input logic [DW-1:0] e, input string t);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b1; addr = AW'(a);
        exp_q.push_back(e);
        tag_q.push_back(t);
        expect_rd = 1'b1;
        @(negedge clk);
        expect_rd = 1'b0;
        ce_n = 1'b1;
    endtask

    task automatic nv_chk(input int a, input logic [DW-1:0] e, input string t);
        nv_addr = AW'(a);
        #0.5;
        chk(nv_rdata === e, t, nv_rdata, e);
    endtask

    // counts cycles busy_n is low, starting from the current (low) cycle
    task automatic count_busy(output int n);
        n = 1;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk); #1;
            if (busy_n) break;
            n++;
        end
    endtask

    task automatic release_store();
        @(negedge clk);
        store_n = 1'b1;
        repeat (RECOV + 2) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        #1;
        // R11: reset state
        chk(busy_n === 1'b1, "R11 busy_n", busy_n, 1);
        chk(rdata_oe === 1'b0, "R11 rdata_oe", rdata_oe, 0);
        nv_chk(0, '0, "R11 shadow");
        rst_n = 1'b1;
        rd(3, '0, "R11 sram zero");

        // R2: write and read back
        for (int i = 0; i < 4; i++) wr(i, pat(i));
        for (int i = 3; i >= 0; i--) rd(i, pat(i), "R2");

        // R1: deselected write has no effect
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b0; addr = 2; wdata = 8'hFF;
        #1;
        chk(rdata_oe === 1'b0, "R1 oe deselect", rdata_oe, 0);
        @(negedge clk);
        we_n = 1'b1;
        rd(2, pat(2), "R1 no write");

        // R4: short pulse ignored
        @(negedge clk);
        store_n = 1'b0;
        repeat (MIN_PULSE - 1) @(negedge clk);
        store_n = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); #1;
            chk(busy_n === 1'b1, "R4 busy", busy_n, 1);
        end
        nv_chk(0, '0, "R4 shadow");

        // R5/R6: dirty store, bus idle
        @(negedge clk);
        store_n = 1'b0;
        for (int k = 1; k <= MIN_PULSE; k++) begin
            @(negedge clk); #1;
            chk(busy_n === 1'b1, "R5 busy before", busy_n, 1);
        end
        @(negedge clk); #1;
        chk(busy_n === 1'b0, "R5 busy low", busy_n, 0);
        n = 1;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (k == 3) begin ce_n = 1'b0; we_n = 1'b1; end
            #1;
            if (k == 3) chk(rdata_oe === 1'b0, "R3 oe in store", rdata_oe, 0);
            if (busy_n) break;
            n++;
        end
        chk(n == 1 + STORE_CYC, "R6 busy cycles", n, 1 + STORE_CYC);
        // R8: inhibit while store_n held low
        chk(rdata_oe === 1'b0, "R8 oe inhibit", rdata_oe, 0);
        @(negedge clk);
        we_n = 1'b0; addr = 0; wdata = 8'hEE;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #1;
            chk(busy_n === 1'b1 && rdata_oe === 1'b0, "R8 hold", busy_n, 1);
        end
        ce_n = 1'b1; we_n = 1'b1;
        for (int i = 0; i < 4; i++) nv_chk(i, pat(i), "R6 shadow copy");
        // R9: recovery blocks access
        @(negedge clk);
        store_n = 1'b1; ce_n = 1'b0; we_n = 1'b0; addr = 1; wdata = 8'h77;
        for (int k = 1; k <= RECOV + 1; k++) begin
            @(negedge clk);
            if (k == 3) we_n = 1'b1;
            #1;
            if (k <= RECOV)
                chk(rdata_oe === 1'b0, "R9 blocked", rdata_oe, 0);
            else
                chk(rdata_oe === 1'b1 && rdata === pat(1), "R9 reopen", rdata, pat(1));
        end
        ce_n = 1'b1; we_n = 1'b1;
        rd(0, pat(0), "R8 write ignored");

        // R7: clean store is skipped
        @(negedge clk);
        store_n = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk); #1;
            if (!busy_n) break;
        end
        count_busy(n);
        chk(n == 2, "R7 skip cycles", n, 2);
        nv_chk(5, '0, "R7 shadow");
        release_store();

        // R10: write finishing in the grace window
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; addr = 5; wdata = 8'hA5; store_n = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk); #1;
            if (!busy_n) break;
        end
        count_busy(n);
        chk(n == GRACE + STORE_CYC, "R10 busy cycles", n, GRACE + STORE_CYC);
        ce_n = 1'b1; we_n = 1'b1;
        nv_chk(5, 8'hA5, "R10 shadow");
        nv_chk(0, pat(0), "R10 shadow keep");
        release_store();
        rd(5, 8'hA5, "R10 sram");

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule